// File: doc/BRIEF.md
# In-Order Retirement Buffer with Block Commit

This block is a circular buffer of in-flight instructions that sits between dispatch and the architected state of an out-of-order core. Dispatch writes one instruction per cycle at the tail and gets back the slot index it was given. Execution units later report completion against that index, along with a fault flag and a branch-mispredict flag. Retirement happens only at the head and only in program order, so the architected register map always matches some point in sequential execution.

Retirement reads one aligned block of `BLK` slots through a single wide port. In one cycle it retires the longest run of finished, fault-free slots that starts at the head and ends inside the head's block. Each retiring lane publishes its destination mapping and returns the superseded physical register to the free list.

A fault is stored in its slot and does nothing until that slot becomes the head. At that point the whole buffer is flushed and fetch is redirected to the fault vector. A mispredicted branch flushes only the slots younger than itself as soon as it completes, which also discards any faults those slots held. An asynchronous interrupt is deferred: the block holds fetch, lets the buffer drain, and redirects to the interrupt vector once it is empty.

Top module: `retire_unit`

## Requirements
- R1: Slots retire only from the head, in program order. A slot retires only if it has completed, carries no fault, and every older slot in the same cycle's run also retires.
- R2: One cycle retires only slots within the aligned block of `BLK` slots that holds the head. Lane j of the commit outputs is slot (block base + j), and several lanes may retire together.
- R3: For each retiring lane, `commit_vld` is set. If the slot has a destination, `commit_wen` is set and `commit_areg`/`commit_preg`/`commit_old_preg` carry the mapping to install and the physical register to free.
- R4: When the head slot has completed with a fault, the block pulses `flush_valid` with cause 2 and `redirect_pc = FAULT_VEC`. It retires nothing that cycle and empties the buffer.
- R5: A completion with the mispredict flag set, for an occupied slot, pulses `flush_valid` with cause 1 and `redirect_pc = cpl_target`. All slots younger than the branch are removed and their buffered faults are never raised. The branch itself remains and retires normally.
- R6: A store retires only in the head's lane, and only while `store_ok` is high. Otherwise it blocks retirement of itself and of every younger slot.
- R7: `disp_ready` is high only if at least `BLK` slots are free, counting from the base of the head's block (space is returned block by block). `disp_idx` is the slot the next dispatch will take. A dispatch is accepted when `disp_valid && disp_ready`.
- R8: A pulse on `irq_req` makes an interrupt pending. While it is pending, `fetch_hold` is high and `disp_ready` is low. Once the buffer is empty, the block pulses `flush_valid` with cause 3 and `redirect_pc = IRQ_VEC`, and the pending state clears.
- R9: If a faulting slot reaches the head while an interrupt is pending, the fault is taken first (cause 2). The interrupt stays pending and is taken after that.
- R10: A completion whose index does not name an occupied slot has no effect: no flush, and no change to any slot.
- R11: After reset the buffer is empty, `disp_ready` is high, and no commit or flush strobe is raised.

Flush cause encoding: 0 none, 1 mispredict, 2 fault, 3 interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | Dispatch accepted this cycle if valid |
| disp_is_store | input | 1 | Instruction is a store |
| disp_has_dest | input | 1 | Instruction writes a register |
| disp_areg | input | AREG_W | Architected destination |
| disp_preg | input | PREG_W | New physical register |
| disp_old_preg | input | PREG_W | Previous mapping of the destination |
| disp_idx | output | $clog2(DEPTH) | Slot assigned to the offered instruction |
| cpl_valid | input | 1 | Completion report |
| cpl_idx | input | $clog2(DEPTH) | Slot that completed |
| cpl_fault | input | 1 | Instruction faulted |
| cpl_mispred | input | 1 | Branch was mispredicted |
| cpl_target | input | PC_W | Correct-path fetch address |
| store_ok | input | 1 | Store path can accept the head store's write |
| irq_req | input | 1 | Asynchronous interrupt request pulse |
| commit_vld | output | BLK | Lane retires this cycle |
| commit_wen | output | BLK | Lane updates the architected map and frees a register |
| commit_areg | output | BLK*AREG_W | Lane architected destination |
| commit_preg | output | BLK*PREG_W | Lane new physical register |
| commit_old_preg | output | BLK*PREG_W | Lane physical register returned to free list |
| flush_valid | output | 1 | Flush and redirect this cycle |
| flush_cause | output | 2 | 1 mispredict, 2 fault, 3 interrupt |
| redirect_pc | output | PC_W | Fetch redirect address |
| fetch_hold | output | 1 | Interrupt pending; front end must stop fetching |

## Verification
The hardest case to reach is a fault arriving at the head while an interrupt drain is under way. It needs a pending interrupt, a partly full buffer, and a faulting slot whose older neighbours retire before the drain finishes. The stimulus reaches it in a phase that pulses interrupts often and marks many completions as faulting, with dispatch kept busy so the buffer is rarely empty when a request lands. A behavioural model of the buffer, kept as sequence numbers, predicts every strobe each cycle. Other phases starve `store_ok` and inject mispredicts over slots that carry buffered faults.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [1:0] {
    FL_NONE    = 2'd0,
    FL_MISPRED = 2'd1,
    FL_FAULT   = 2'd2,
    FL_IRQ     = 2'd3
  } flush_cause_e;
endpackage

// File: rtl/retire_slot_array.sv
module retire_slot_array #(
  parameter int DEPTH  = 16,
  parameter int BLK    = 4,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  localparam int IW = $clog2(DEPTH),
  localparam int NB = DEPTH / BLK,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_en,
  input  logic [IW-1:0]                  alloc_idx,
  input  logic                           alloc_st,
  input  logic                           alloc_hd,
  input  logic [AREG_W-1:0]              alloc_areg,
  input  logic [PREG_W-1:0]              alloc_preg,
  input  logic [PREG_W-1:0]              alloc_old,
  input  logic                           mark_en,
  input  logic [IW-1:0]                  mark_idx,
  input  logic                           mark_fault,
  input  logic [BW-1:0]                  rd_blk,
  output logic [BLK-1:0]                 lane_done,
  output logic [BLK-1:0]                 lane_fault,
  output logic [BLK-1:0]                 lane_st,
  output logic [BLK-1:0]                 lane_hd,
  output logic [BLK-1:0][AREG_W-1:0]     lane_areg,
  output logic [BLK-1:0][PREG_W-1:0]     lane_preg,
  output logic [BLK-1:0][PREG_W-1:0]     lane_old
);
  logic [DEPTH-1:0]  done_q, fault_q, st_q, hd_q;
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [PREG_W-1:0] preg_q [DEPTH];
  logic [PREG_W-1:0] old_q  [DEPTH];

  // completion state needs a defined reset; payload does not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      fault_q <= '0;
    end else begin
      if (alloc_en) begin
        done_q[alloc_idx]  <= 1'b0;
        fault_q[alloc_idx] <= 1'b0;
      end
      if (mark_en) begin
        done_q[mark_idx]  <= 1'b1;
        fault_q[mark_idx] <= mark_fault;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      st_q[alloc_idx]   <= alloc_st;
      hd_q[alloc_idx]   <= alloc_hd;
      areg_q[alloc_idx] <= alloc_areg;
      preg_q[alloc_idx] <= alloc_preg;
      old_q[alloc_idx]  <= alloc_old;
    end
  end

  // one wide read of the aligned block holding the head
  for (genvar j = 0; j < BLK; j++) begin : g_lane
    logic [IW-1:0] slot;
    assign slot          = IW'(int'(rd_blk) * BLK + j);
    assign lane_done[j]  = done_q[slot];
    assign lane_fault[j] = fault_q[slot];
    assign lane_st[j]    = st_q[slot];
    assign lane_hd[j]    = hd_q[slot];
    assign lane_areg[j]  = areg_q[slot];
    assign lane_preg[j]  = preg_q[slot];
    assign lane_old[j]   = old_q[slot];
  end
endmodule

// File: rtl/retire_block_picker.sv
module retire_block_picker #(
  parameter int BLK = 4,
  parameter int PW  = 5,
  localparam int LBW = $clog2(BLK)
) (
  input  logic [LBW-1:0] h0,
  input  logic [PW-1:0]  cnt,
  input  logic           store_ok,
  input  logic [BLK-1:0] lane_done,
  input  logic [BLK-1:0] lane_fault,
  input  logic [BLK-1:0] lane_st,
  output logic [BLK-1:0] commit,
  output logic           fault_head
);
  logic [BLK-1:0] elig, go;

  for (genvar j = 0; j < BLK; j++) begin : g_pick
    logic live;
    assign live    = (j >= int'(h0)) && ((j - int'(h0)) < int'(cnt));
    assign elig[j] = live && lane_done[j] && !lane_fault[j] &&
                     (!lane_st[j] || ((int'(h0) == j) && store_ok));
    if (j == 0) begin : g_first
      assign go[j] = (h0 == '0);
    end else begin : g_rest
      assign go[j] = (int'(h0) == j) || commit[j-1];
    end
    assign commit[j] = go[j] && elig[j];
  end

  assign fault_head = (cnt != '0) && lane_done[h0] && lane_fault[h0];
endmodule

// File: rtl/retire_event_arbiter.sv
module retire_event_arbiter
  import retire_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] FAULT_VEC = 32'h0000_0100,
  parameter logic [PC_W-1:0] IRQ_VEC   = 32'h0000_0200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_head,
  input  logic            cpl_live,
  input  logic            cpl_mispred,
  input  logic [PC_W-1:0] cpl_target,
  input  logic            empty,
  input  logic            irq_req,
  output logic            fault_take,
  output logic            misp_take,
  output logic            irq_pend,
  output logic            flush_valid,
  output flush_cause_e    flush_cause,
  output logic [PC_W-1:0] redirect_pc
);
  logic irq_take;

  assign fault_take = fault_head;
  assign misp_take  = cpl_live && cpl_mispred && !fault_head;
  assign irq_take   = irq_pend && empty && !fault_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pend <= 1'b0;
    else        irq_pend <= irq_req || (irq_pend && !irq_take);
  end

  always_comb begin
    flush_valid = 1'b1;
    flush_cause = FL_NONE;
    redirect_pc = '0;
    if (fault_take) begin
      flush_cause = FL_FAULT;
      redirect_pc = FAULT_VEC;
    end else if (misp_take) begin
      flush_cause = FL_MISPRED;
      redirect_pc = cpl_target;
    end else if (irq_take) begin
      flush_cause = FL_IRQ;
      redirect_pc = IRQ_VEC;
    end else begin
      flush_valid = 1'b0;
    end
  end
endmodule

// File: rtl/retire_unit.sv
module retire_unit
  import retire_pkg::*;
#(
  parameter int              DEPTH     = 16,
  parameter int              BLK       = 4,
  parameter int              AREG_W    = 5,
  parameter int              PREG_W    = 6,
  parameter int              PC_W      = 32,
  parameter logic [PC_W-1:0] FAULT_VEC = 32'h0000_0100,
  parameter logic [PC_W-1:0] IRQ_VEC   = 32'h0000_0200
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  output logic                       disp_ready,
  input  logic                       disp_is_store,
  input  logic                       disp_has_dest,
  input  logic [AREG_W-1:0]          disp_areg,
  input  logic [PREG_W-1:0]          disp_preg,
  input  logic [PREG_W-1:0]          disp_old_preg,
  output logic [$clog2(DEPTH)-1:0]   disp_idx,
  input  logic                       cpl_valid,
  input  logic [$clog2(DEPTH)-1:0]   cpl_idx,
  input  logic                       cpl_fault,
  input  logic                       cpl_mispred,
  input  logic [PC_W-1:0]            cpl_target,
  input  logic                       store_ok,
  input  logic                       irq_req,
  output logic [BLK-1:0]             commit_vld,
  output logic [BLK-1:0]             commit_wen,
  output logic [BLK-1:0][AREG_W-1:0] commit_areg,
  output logic [BLK-1:0][PREG_W-1:0] commit_preg,
  output logic [BLK-1:0][PREG_W-1:0] commit_old_preg,
  output logic                       flush_valid,
  output logic [1:0]                 flush_cause,
  output logic [PC_W-1:0]            redirect_pc,
  output logic                       fetch_hold
);
  localparam int IW  = $clog2(DEPTH);
  localparam int PW  = IW + 1;
  localparam int LBW = $clog2(BLK);
  localparam int NB  = DEPTH / BLK;
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1;

  // pointers carry one wrap bit so full and empty differ
  logic [PW-1:0] head_q, tail_q, cnt, used, base_ptr, n_commit;
  logic [IW-1:0] cpl_off;
  logic          cpl_live, fault_take, misp_take, irq_pend, disp_fire;
  logic [BLK-1:0] lane_done, lane_fault, lane_st, lane_hd, commit_mask;
  flush_cause_e   cause;

  assign cnt      = tail_q - head_q;
  assign base_ptr = {head_q[PW-1:LBW], {LBW{1'b0}}};
  assign used     = tail_q - base_ptr;
  assign cpl_off  = cpl_idx - head_q[IW-1:0];
  assign cpl_live = cpl_valid && ({1'b0, cpl_off} < cnt);
  assign n_commit = PW'($countones(commit_mask));

  assign disp_ready = (used <= PW'(DEPTH - BLK)) && !irq_pend && !fault_take && !misp_take;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_idx   = tail_q[IW-1:0];
  assign fetch_hold = irq_pend;

  retire_slot_array #(
    .DEPTH(DEPTH), .BLK(BLK), .AREG_W(AREG_W), .PREG_W(PREG_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (disp_fire),
    .alloc_idx  (tail_q[IW-1:0]),
    .alloc_st   (disp_is_store),
    .alloc_hd   (disp_has_dest),
    .alloc_areg (disp_areg),
    .alloc_preg (disp_preg),
    .alloc_old  (disp_old_preg),
    .mark_en    (cpl_live && !fault_take),
    .mark_idx   (cpl_idx),
    .mark_fault (cpl_fault),
    .rd_blk     (BW'(head_q[IW-1:LBW])),
    .lane_done  (lane_done),
    .lane_fault (lane_fault),
    .lane_st    (lane_st),
    .lane_hd    (lane_hd),
    .lane_areg  (commit_areg),
    .lane_preg  (commit_preg),
    .lane_old   (commit_old_preg)
  );

  retire_block_picker #(.BLK(BLK), .PW(PW)) u_pick (
    .h0         (head_q[LBW-1:0]),
    .cnt        (cnt),
    .store_ok   (store_ok),
    .lane_done  (lane_done),
    .lane_fault (lane_fault),
    .lane_st    (lane_st),
    .commit     (commit_mask),
    .fault_head (fault_take)
  );

  retire_event_arbiter #(
    .PC_W(PC_W), .FAULT_VEC(FAULT_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_head  (fault_take),
    .cpl_live    (cpl_live),
    .cpl_mispred (cpl_mispred),
    .cpl_target  (cpl_target),
    .empty       (cnt == '0),
    .irq_req     (irq_req),
    .fault_take  (),
    .misp_take   (misp_take),
    .irq_pend    (irq_pend),
    .flush_valid (flush_valid),
    .flush_cause (cause),
    .redirect_pc (redirect_pc)
  );

  assign flush_cause = cause;
  assign commit_vld  = commit_mask;
  assign commit_wen  = commit_mask & lane_hd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (fault_take) begin
      tail_q <= head_q;
    end else begin
      head_q <= head_q + n_commit;
      if (misp_take)      tail_q <= head_q + {1'b0, cpl_off} + PW'(1);
      else if (disp_fire) tail_q <= tail_q + PW'(1);
    end
  end
endmodule

// File: rtl/retire_unit_chk.sv
module retire_unit_chk #(
  parameter int DEPTH = 16,
  parameter int BLK   = 4,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PW-1:0]  head_q,
  input logic [PW-1:0]  tail_q,
  input logic           disp_ready,
  input logic           fetch_hold,
  input logic [BLK-1:0] commit_vld,
  input logic           flush_valid,
  input logic [1:0]     flush_cause
);
  logic [PW-1:0] occ;
  assign occ = tail_q - head_q;

  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_cause == 2'd2) |-> (commit_vld == '0));

  assert_fault_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_cause == 2'd2) |=> (head_q == tail_q));

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  assert_irq_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_cause == 2'd3) |-> (head_q == tail_q));

  assert_hold_blocks_dispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hold |-> !disp_ready);

  assert_commit_within_occupancy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld != '0) |-> ($countones(commit_vld) <= int'(occ)));
endmodule

bind retire_unit retire_unit_chk #(.DEPTH(DEPTH), .BLK(BLK)) u_retire_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .head_q      (head_q),
  .tail_q      (tail_q),
  .disp_ready  (disp_ready),
  .fetch_hold  (fetch_hold),
  .commit_vld  (commit_vld),
  .flush_valid (flush_valid),
  .flush_cause (flush_cause)
);

// File: tb/test_retire_unit.sv
`timescale 1ns/1ps
module test_retire_unit;
  localparam int D = 16, B = 4, AW = 5, PRW = 6, PCW = 32;
  localparam int IW = $clog2(D);
  localparam logic [PCW-1:0] FV = 32'h0000_0100, IV = 32'h0000_0200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic disp_valid, disp_ready, disp_is_store, disp_has_dest;
  logic [AW-1:0] disp_areg;
  logic [PRW-1:0] disp_preg, disp_old_preg;
  logic [IW-1:0] disp_idx, cpl_idx;
  logic cpl_valid, cpl_fault, cpl_mispred, store_ok, irq_req;
  logic [PCW-1:0] cpl_target, redirect_pc;
  logic [B-1:0] commit_vld, commit_wen;
  logic [B-1:0][AW-1:0] commit_areg;
  logic [B-1:0][PRW-1:0] commit_preg, commit_old_preg;
  logic flush_valid, fetch_hold;
  logic [1:0] flush_cause;

  retire_unit #(.DEPTH(D), .BLK(B), .AREG_W(AW), .PREG_W(PRW), .PC_W(PCW),
                .FAULT_VEC(FV), .IRQ_VEC(IV)) i_retire_unit (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: absolute sequence numbers, slot = seq % D
  int mh, mt;
  bit pend;
  bit md[D], mf[D], ms[D], mhd[D];
  int mar[D], mp[D], mo[D];

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pd, pc, pfl, pm, pso, pi;
    disp_valid = 0; disp_is_store = 0; disp_has_dest = 0; disp_areg = '0;
    disp_preg = '0; disp_old_preg = '0; cpl_valid = 0; cpl_idx = '0;
    cpl_fault = 0; cpl_mispred = 0; cpl_target = '0; store_ok = 0; irq_req = 0;
    mh = 0; mt = 0; pend = 0;
    for (int k = 0; k < D; k++) begin md[k] = 0; mf[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 ready", disp_ready, 1);
    chk("R11 commit", commit_vld, 0);
    chk("R11 flush", flush_valid, 0);
    chk("R11 hold", fetch_hold, 0);
    chk("R11 idx", disp_idx, 0);

    for (int ph = 0; ph < 4; ph++) begin
      case (ph)
        0: begin pd = 95; pc = 70; pfl = 0;  pm = 0;  pso = 100; pi = 0; end
        1: begin pd = 70; pc = 60; pfl = 10; pm = 6;  pso = 60;  pi = 0; end
        2: begin pd = 80; pc = 70; pfl = 15; pm = 3;  pso = 80;  pi = 4; end
        default: begin pd = 60; pc = 50; pfl = 8; pm = 10; pso = 20; pi = 2; end
      endcase
      for (int cyc = 0; cyc < 2000; cyc++) begin
        int cnt, h0, base, hi, off, used, ncom, mh_old, found;
        bit fth, live, mis, irqt, rdy, run, oow;
        bit [B-1:0] ecv, ecw;
        @(negedge clk);
        cnt = mt - mh;
        // stimulus from model state
        disp_valid    = ($urandom % 100) < pd;
        disp_is_store = ($urandom % 4) == 0;
        disp_has_dest = ($urandom % 5) != 0;
        disp_areg     = AW'($urandom);
        disp_preg     = PRW'($urandom);
        disp_old_preg = PRW'($urandom);
        store_ok      = ($urandom % 100) < pso;
        irq_req       = ($urandom % 100) < pi;
        cpl_fault     = ($urandom % 100) < pfl;
        cpl_mispred   = ($urandom % 100) < pm;
        cpl_target    = $urandom;
        cpl_valid     = 0;
        oow           = 0;
        if (cnt < D && ($urandom % 100) < 4) begin
          cpl_valid = 1; oow = 1;
          cpl_idx = IW'((mh + cnt + int'($urandom % (D - cnt))) % D);
        end else if (cnt > 0 && ($urandom % 100) < pc) begin
          int st;
          st = $urandom % cnt;
          found = -1;
          for (int k = 0; k < cnt; k++)
            if (found < 0 && !md[(mh + (st + k) % cnt) % D]) found = (mh + (st + k) % cnt) % D;
          if (found >= 0) begin cpl_valid = 1; cpl_idx = IW'(found); end
        end
        #1;
        // expected outputs
        h0 = mh % B; base = mh - h0; hi = mh % D;
        fth  = cnt > 0 && md[hi] && mf[hi];
        off  = (int'(cpl_idx) - hi + D) % D;
        live = cpl_valid && off < cnt;
        mis  = live && cpl_mispred && !fth;
        irqt = !fth && pend && cnt == 0;
        used = mt - base;
        rdy  = (D - used >= B) && !pend && !fth && !mis;
        run = 1; ecv = '0; ecw = '0; ncom = 0;
        for (int j = 0; j < B; j++) begin
          if (j >= h0) begin
            int s, k;
            bit e;
            s = base + j; k = s % D;
            e = run && s < mt && md[k] && !mf[k] && (!ms[k] || (j == h0 && store_ok));
            if (!e) run = 0;
            ecv[j] = e; ecw[j] = e && mhd[k];
            if (e) ncom++;
          end
        end
        // compare
        chk(oow ? "R10 ready" : (pend ? "R8 ready" : "R7 ready"), disp_ready, rdy);
        chk("R7 idx", disp_idx, mt % D);
        chk("R8 hold", fetch_hold, pend);
        for (int j = 0; j < B; j++) begin
          int k;
          k = (base + j) % D;
          chk(ms[k] ? "R6 store lane" : (j == h0 ? "R1 head lane" : "R2 block lane"),
              commit_vld[j], ecv[j]);
          if (ecv[j]) begin
            chk("R3 wen", commit_wen[j], ecw[j]);
            if (ecw[j]) begin
              chk("R3 areg", commit_areg[j], mar[k]);
              chk("R3 preg", commit_preg[j], mp[k]);
              chk("R3 oldpreg", commit_old_preg[j], mo[k]);
            end
          end
        end
        chk(oow ? "R10 flush" : "R1 flush", flush_valid, fth || mis || irqt);
        if (fth) begin
          chk(pend ? "R9 cause" : "R4 cause", flush_cause, 2);
          chk("R4 pc", redirect_pc, FV);
        end else if (mis) begin
          chk("R5 cause", flush_cause, 1);
          chk("R5 pc", redirect_pc, cpl_target);
        end else if (irqt) begin
          chk("R8 cause", flush_cause, 3);
          chk("R8 pc", redirect_pc, IV);
        end
        // model update at the edge
        @(posedge clk);
        mh_old = mh;
        if (fth) mt = mh;
        else begin
          mh = mh + ncom;
          if (mis) mt = mh_old + off + 1;
          else if (disp_valid && rdy) begin
            int k;
            k = mt % D;
            md[k] = 0; mf[k] = 0; ms[k] = disp_is_store; mhd[k] = disp_has_dest;
            mar[k] = disp_areg; mp[k] = disp_preg; mo[k] = disp_old_preg;
            mt++;
          end
        end
        if (live && !fth) begin md[cpl_idx] = 1; mf[cpl_idx] = cpl_fault; end
        pend = irq_req || (pend && !irqt);
      end
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule